// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block lets clocked logic use an external asynchronous static RAM of 131,072 bytes. The host presents a request with a direction flag, a 17-bit word address and a write byte. The controller then runs one complete memory cycle on the pins and returns to idle. A read ends with the byte on `rdata` and a single-cycle `rvalid` pulse.

On the memory side the block drives the address bus and two chip selects of opposite polarity: `mem_sel_n` is active low and `mem_sel` is active high. It also drives a write strobe and a read strobe, both active low. The 8-bit data bus is split into an outgoing byte, an incoming byte and a drive-enable for the controller's own pad drivers. Every analogue timing minimum is a nanosecond parameter. Each one is turned into a whole number of clocks by ceiling division against `CLK_NS`, and every nonzero minimum gets at least one clock.

A write commits on the rising edge of the write strobe, and the byte is held through that edge. After a read, the read strobe stays high for a float-time window before the controller may drive the bus again.

Top module: `sram_async_ctl`

## Requirements
- R1: While `rst_n` is low, at the next clock edge the outputs become: `mem_sel_n`=1, `mem_sel`=0, `mem_wr_n`=1, `mem_rd_n`=1, `mem_dq_oe`=0, `rvalid`=0. `ready` reads 1.
- R2: Whenever `ready` is 1 (idle), `mem_sel_n` is 1 and `mem_dq_oe` is 0.
- R3: A read holds `mem_sel_n`=0, `mem_sel`=1, `mem_wr_n`=1 and `mem_rd_n`=0 for the read window. It returns on `rdata` the byte the memory presents for the accepted address.
- R4: For the whole time `mem_wr_n` is 0, both selects are active and `mem_dq_oe` is 1. On the cycle after `mem_wr_n` rises, the selects are still active, `mem_dq_oe` is still 1 and `mem_dq_out` is unchanged. The memory therefore stores the host's byte at the host's address.
- R5: `mem_dq_oe` and an active-low `mem_rd_n` are never 1 and 0 together.
- R6: `mem_dq_oe` rises only after `mem_rd_n` has been high for at least the float window plus one idle cycle, measured since the end of the last read.
- R7: `mem_dq_oe` is 0 on the second cycle after `mem_wr_n` rises.
- R8: `ready` is 0 from the accepting edge until the transaction finishes. A request presented while `ready` is 0 is ignored and causes no memory cycle.
- R9: `rvalid` is a single-cycle pulse, issued exactly once per read and never for a write.
- R10: The read window lasts ceil(max(t_aa, t_oe, t_rc)/CLK_NS) clocks. The write pulse lasts max(ceil(t_wp), ceil(t_aw), ceil(t_dw), ceil(t_wc)−1) clocks. The float window lasts ceil(t_ohz) clocks. Each count is at least 1. `ready` is low for read window plus float window on a read, and for write pulse plus 1 on a write.
- R11: `mem_addr` is stable while `mem_wr_n` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Host request, taken when `ready` is 1 |
| host_wr | input | 1 | 1 = write, 0 = read |
| addr | input | 17 | Host byte address |
| wdata | input | 8 | Host write byte |
| ready | output | 1 | Idle and able to take a request |
| rdata | output | 8 | Last read byte |
| rvalid | output | 1 | One-cycle pulse when `rdata` is new |
| mem_addr | output | 17 | Memory address bus |
| mem_sel_n | output | 1 | Active-low chip select |
| mem_sel | output | 1 | Active-high chip select |
| mem_wr_n | output | 1 | Active-low write strobe |
| mem_rd_n | output | 1 | Active-low output (read) strobe |
| mem_dq_out | output | 8 | Byte the controller drives onto the data bus |
| mem_dq_oe | output | 1 | Enable for the controller's data drivers |
| mem_dq_in | input | 8 | Byte seen on the data bus |

## Verification
The bench goes after three corner cases. The first is a write issued straight after a read: a controller that skipped the float window would raise its drivers while the memory might still be driving. The second is the edge where the write strobe rises: a design that dropped its drivers or the select on that same edge would latch a floating byte, and the memory model would store the wrong value. The third is requests held high while the block is busy: a design that looked at `req` outside idle would start a second memory cycle, which shows up as an extra write or an extra `rvalid`. Timing parameters of a slower speed grade force multi-cycle windows, so off-by-one errors in the ceiling conversion change the measured strobe widths.

// File: rtl/sram_async_pkg.sv
// Shared types and cycle-conversion helpers for the asynchronous SRAM controller.
// Assumes all timing values are non-negative nanosecond integers.
package sram_async_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD,
        ST_RTURN,
        ST_WR,
        ST_WHOLD
    } seq_state_e;

    // Ceiling conversion of a nanosecond minimum into clocks; zero stays zero.
    function automatic int ns_to_cyc(input int ns, input int clk_ns);
        if (ns <= 0) return 0;
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_async_timer.sv
// Down-counter that times each phase of a memory cycle.
// Assumes the sequencer loads (phase length - 1); done is high when the count is zero.
module sram_async_timer #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);

    logic [CNT_W-1:0] cnt_q;

    // Load a new phase length or count down towards zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);

    // A loaded count must reach zero one clock at a time.
    p_count_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(load) && $past(cnt_q) != '0) |-> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/sram_async_seq.sv
// Cycle sequencer: walks idle -> read window -> float window, or idle -> write pulse -> hold.
// Assumes the memory strobes are registered from the next state, so pins never glitch.
module sram_async_seq #(
    parameter int RD_N   = 1,
    parameter int WR_N   = 1,
    parameter int TURN_N = 1,
    parameter int CNT_W  = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             host_wr,
    input  logic             tmr_done,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic             ready,
    output logic             accept,
    output logic             capture,
    output logic             mem_sel_n,
    output logic             mem_sel,
    output logic             mem_wr_n,
    output logic             mem_rd_n,
    output logic             mem_dq_oe
);
    import sram_async_pkg::*;

    localparam logic [CNT_W-1:0] RD_LD   = CNT_W'(RD_N - 1);
    localparam logic [CNT_W-1:0] WR_LD   = CNT_W'(WR_N - 1);
    localparam logic [CNT_W-1:0] TURN_LD = CNT_W'(TURN_N - 1);

    seq_state_e state_q, state_d;
    logic       sel_d;

    // Next-state and timer-load decisions.
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        capture  = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (req) begin
                    tmr_load = 1'b1;
                    if (host_wr) begin
                        state_d = ST_WR;
                        tmr_val = WR_LD;
                    end else begin
                        state_d = ST_RD;
                        tmr_val = RD_LD;
                    end
                end
            end
            ST_RD: begin
                if (tmr_done) begin
                    capture  = 1'b1;
                    state_d  = ST_RTURN;
                    tmr_load = 1'b1;
                    tmr_val  = TURN_LD;
                end
            end
            ST_RTURN: if (tmr_done) state_d = ST_IDLE;
            ST_WR:    if (tmr_done) state_d = ST_WHOLD;
            ST_WHOLD: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    assign ready  = (state_q == ST_IDLE);
    assign accept = ready && req;
    assign sel_d  = (state_d == ST_RD) || (state_d == ST_WR) || (state_d == ST_WHOLD);

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Registered memory strobes decoded from the next state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_sel_n <= 1'b1;
            mem_sel   <= 1'b0;
            mem_wr_n  <= 1'b1;
            mem_rd_n  <= 1'b1;
            mem_dq_oe <= 1'b0;
        end else begin
            mem_sel_n <= !sel_d;
            mem_sel   <= sel_d;
            mem_wr_n  <= (state_d != ST_WR);
            mem_rd_n  <= (state_d != ST_RD);
            mem_dq_oe <= (state_d == ST_WR) || (state_d == ST_WHOLD);
        end
    end

    // Our drivers and the memory's drivers never overlap.
    p_no_contention_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_rd_n);

    // Drivers come on only after the read strobe was already high.
    p_turnaround_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe) |-> $past(mem_rd_n));

    // Drivers are released one cycle after the write edge.
    p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_wr_n) |=> !mem_dq_oe);

    // A low write strobe always has both selects and our data driven.
    p_write_enables_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_wr_n |-> (!mem_sel_n && mem_sel && mem_dq_oe));

    // The byte is still driven with the chip selected on the cycle after the write edge.
    p_write_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_wr_n) |-> (mem_dq_oe && !mem_sel_n));

    // Idle keeps the chip deselected and the bus released.
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (mem_sel_n && !mem_dq_oe));

endmodule

// File: rtl/sram_async_dpath.sv
// Address/data holding registers and read capture.
// Assumes accept and capture come from the sequencer and are single-cycle.
module sram_async_dpath #(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              capture,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);

    // Hold address and write byte for the whole memory cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr   <= '0;
            mem_dq_out <= '0;
        end else if (accept) begin
            mem_addr   <= addr;
            mem_dq_out <= wdata;
        end
    end

    // Sample the bus on the last read-window cycle and flag it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= capture;
            if (capture) rdata <= mem_dq_in;
        end
    end

    // rvalid never lasts two cycles.
    p_rvalid_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |=> !rvalid);

endmodule

// File: rtl/sram_async_ctl.sv
// Top of the asynchronous SRAM controller: converts nanosecond minimums into clock
// counts and wires sequencer, phase timer and datapath together.
// Assumes CLK_NS > 0 and a host that holds its request fields while req is high.
module sram_async_ctl #(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8,
    parameter int CLK_NS = 10,
    parameter int T_AA   = 10,
    parameter int T_OE   = 5,
    parameter int T_RC   = 10,
    parameter int T_WP   = 7,
    parameter int T_AW   = 8,
    parameter int T_DW   = 5,
    parameter int T_WC   = 10,
    parameter int T_OHZ  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              ready,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_sel_n,
    output logic              mem_sel,
    output logic              mem_wr_n,
    output logic              mem_rd_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    import sram_async_pkg::*;

    localparam int RD_N = max2(1, max2(max2(ns_to_cyc(T_AA, CLK_NS), ns_to_cyc(T_OE, CLK_NS)),
                                       ns_to_cyc(T_RC, CLK_NS)));
    localparam int WR_N = max2(1, max2(max2(ns_to_cyc(T_WP, CLK_NS), ns_to_cyc(T_AW, CLK_NS)),
                                       max2(ns_to_cyc(T_DW, CLK_NS), ns_to_cyc(T_WC, CLK_NS) - 1)));
    localparam int TURN_N = max2(1, ns_to_cyc(T_OHZ, CLK_NS));
    localparam int N_MAX  = max2(RD_N, max2(WR_N, TURN_N));
    localparam int CNT_W  = max2(1, $clog2(N_MAX));

    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_done;
    logic             accept;
    logic             capture;

    sram_async_seq #(
        .RD_N   (RD_N),
        .WR_N   (WR_N),
        .TURN_N (TURN_N),
        .CNT_W  (CNT_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .host_wr   (host_wr),
        .tmr_done  (tmr_done),
        .tmr_load  (tmr_load),
        .tmr_val   (tmr_val),
        .ready     (ready),
        .accept    (accept),
        .capture   (capture),
        .mem_sel_n (mem_sel_n),
        .mem_sel   (mem_sel),
        .mem_wr_n  (mem_wr_n),
        .mem_rd_n  (mem_rd_n),
        .mem_dq_oe (mem_dq_oe)
    );

    sram_async_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    sram_async_dpath #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_dpath (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .capture    (capture),
        .addr       (addr),
        .wdata      (wdata),
        .mem_dq_in  (mem_dq_in),
        .mem_addr   (mem_addr),
        .mem_dq_out (mem_dq_out),
        .rdata      (rdata),
        .rvalid     (rvalid)
    );

    // Address must not move under a low write strobe.
    p_addr_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_wr_n && $past(!mem_wr_n)) |-> $stable(mem_addr));

    // No read result appears while a write is on the pins.
    p_no_rvalid_in_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_wr_n |-> !rvalid);

    // Busy means a cycle is under way: ready returns only with the bus released.
    p_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_rd_n || !mem_wr_n) |-> !ready);

endmodule

// File: tb/sram_async_ctl_tb.sv
// Self-checking bench: pin-level memory model, reference byte store, directed and random traffic.
module sram_async_ctl_tb;

    localparam int CLK_NS = 10;
    localparam int T_AA = 20, T_OE = 8, T_RC = 20;
    localparam int T_WP = 12, T_AW = 12, T_DW = 10, T_WC = 20, T_OHZ = 7;

    // Expected clock counts, worked out from the requirements.
    function automatic int cdiv(input int ns);
        return (ns + CLK_NS - 1) / CLK_NS;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction
    localparam int RD_EXP   = mx(1, mx(cdiv(T_AA), mx(cdiv(T_OE), cdiv(T_RC))));
    localparam int WP_EXP   = mx(1, mx(mx(cdiv(T_WP), cdiv(T_AW)), mx(cdiv(T_DW), cdiv(T_WC) - 1)));
    localparam int TURN_EXP = mx(1, cdiv(T_OHZ));

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        host_wr = 1'b0;
    logic [16:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic        ready;
    logic [7:0]  rdata;
    logic        rvalid;
    logic [16:0] mem_addr;
    logic        mem_sel_n, mem_sel, mem_wr_n, mem_rd_n, mem_dq_oe;
    logic [7:0]  mem_dq_out;
    logic [7:0]  mem_dq_in = 8'hEE;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    sram_async_ctl #(
        .CLK_NS(CLK_NS), .T_AA(T_AA), .T_OE(T_OE), .T_RC(T_RC), .T_WP(T_WP),
        .T_AW(T_AW), .T_DW(T_DW), .T_WC(T_WC), .T_OHZ(T_OHZ)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .req(req), .host_wr(host_wr), .addr(addr), .wdata(wdata),
        .ready(ready), .rdata(rdata), .rvalid(rvalid), .mem_addr(mem_addr),
        .mem_sel_n(mem_sel_n), .mem_sel(mem_sel), .mem_wr_n(mem_wr_n), .mem_rd_n(mem_rd_n),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    // Contents of a never-written location.
    function automatic logic [7:0] init_val(input logic [16:0] a);
        return a[7:0] ^ a[16:9] ^ 8'h5A;
    endfunction

    logic [7:0] mem_arr [int];   // pin-level memory model
    logic [7:0] ref_arr [int];   // bench reference
    logic [7:0] exp_q [$];

    function automatic logic [7:0] mem_rd(input logic [16:0] a);
        return mem_arr.exists(int'(a)) ? mem_arr[int'(a)] : init_val(a);
    endfunction
    function automatic logic [7:0] ref_rd(input logic [16:0] a);
        return ref_arr.exists(int'(a)) ? ref_arr[int'(a)] : init_val(a);
    endfunction

    // Monitor state
    logic        prev_wr_n = 1'b1, prev_sel_ok = 1'b0, prev_rd_n = 1'b1, prev_oe = 1'b0, prev_rvalid = 1'b0;
    logic [16:0] prev_addr = '0;
    logic [7:0]  prev_dout = '0;
    int          wr_low = 0, rd_low = 0, rd_high_run = 100;
    bit          release_due = 0;
    int          pin_writes = 0, host_writes = 0, host_reads = 0, rvalids = 0;
    int          contention = 0, idle_bad = 0;

    // Pin-level observer and memory model, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_dq_oe && !mem_rd_n) contention++;
            if (ready && (!mem_sel_n || mem_dq_oe)) idle_bad++;
            if (release_due) begin
                chk(!mem_dq_oe, "R7 drivers off after write edge", mem_dq_oe, 0);
                release_due = 0;
            end
            if (!mem_wr_n) begin
                wr_low++;
                if (!(!mem_sel_n && mem_sel && mem_dq_oe)) chk(0, "R4 selects/drivers during write pulse", {mem_sel_n, mem_sel, mem_dq_oe}, 3'b011);
                if (!prev_wr_n && mem_addr != prev_addr) chk(0, "R11 address moved in pulse", mem_addr, prev_addr);
            end
            if (!prev_wr_n && mem_wr_n) begin
                chk(prev_sel_ok && !mem_sel_n && mem_sel && mem_dq_oe && mem_dq_out == prev_dout,
                    "R4 hold cycle after write edge", mem_dq_out, prev_dout);
                chk(wr_low == WP_EXP, "R10 write pulse width", wr_low, WP_EXP);
                mem_arr[int'(prev_addr)] = prev_dout;
                pin_writes++;
                wr_low = 0;
                release_due = 1;
            end
            if (!mem_rd_n) begin
                rd_low++;
                if (!(!mem_sel_n && mem_sel && mem_wr_n)) chk(0, "R3 read pin levels", {mem_sel_n, mem_sel, mem_wr_n}, 3'b011);
            end
            if (!prev_rd_n && mem_rd_n) begin
                chk(rd_low == RD_EXP, "R10 read window width", rd_low, RD_EXP);
                rd_low = 0;
            end
            if (!prev_oe && mem_dq_oe)
                chk(rd_high_run >= TURN_EXP + 1, "R6 float window before drive", rd_high_run, TURN_EXP + 1);
            rd_high_run = mem_rd_n ? rd_high_run + 1 : 0;
            if (rvalid) begin
                rvalids++;
                if (prev_rvalid) chk(0, "R9 rvalid longer than one cycle", 2, 1);
                if (exp_q.size() == 0) chk(0, "R9 rvalid without read", 1, 0);
                else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    chk(rdata == e, "R3 read data", rdata, e);
                end
            end
        end
        prev_wr_n   = mem_wr_n;
        prev_rd_n   = mem_rd_n;
        prev_oe     = mem_dq_oe;
        prev_rvalid = rvalid;
        prev_addr   = mem_addr;
        prev_dout   = mem_dq_out;
        prev_sel_ok = !mem_sel_n && mem_sel;
        // Memory drives the bus only when selected, read-strobed and not writing.
        mem_dq_in = (!mem_sel_n && mem_sel && mem_wr_n && !mem_rd_n) ? mem_rd(mem_addr) : 8'hEE;
    end

    // One host transaction; optionally keeps req high with junk while busy (R8).
    task automatic op(input bit wr, input logic [16:0] a, input logic [7:0] d, input bit busy_req);
        int busy;
        while (!ready) @(negedge clk);
        req = 1'b1; host_wr = wr; addr = a; wdata = d;
        if (wr) begin
            ref_arr[int'(a)] = d;
            host_writes++;
        end else begin
            exp_q.push_back(ref_rd(a));
            host_reads++;
        end
        @(negedge clk);
        busy = 0;
        while (!ready) begin
            busy++;
            req = busy_req; host_wr = 1'b1; addr = a ^ 17'h1; wdata = ~d;
            @(negedge clk);
        end
        req = 1'b0;
        if (wr) chk(busy == WP_EXP + 1, "R8 R10 busy length of write", busy, WP_EXP + 1);
        else    chk(busy == RD_EXP + TURN_EXP, "R8 R10 busy length of read", busy, RD_EXP + TURN_EXP);
    endtask

    task automatic finish_up();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual hung expected done");
        finish_up();
    end

    initial begin
        void'($urandom(32'h5EED));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(mem_sel_n && !mem_sel && mem_wr_n && mem_rd_n && !mem_dq_oe && !rvalid && ready,
            "R1 reset state", {mem_sel_n, mem_sel, mem_wr_n, mem_rd_n, mem_dq_oe, rvalid, ready}, 7'b1011001);
        rst_n = 1'b1;
        @(negedge clk);
        // Directed: corners of the address range, write then read back.
        op(1, 17'h00000, 8'hA5, 0);
        op(1, 17'h1FFFF, 8'h3C, 0);
        op(0, 17'h00000, 8'h00, 0);
        op(0, 17'h1FFFF, 8'h00, 0);
        // Read of a never-written location.
        op(0, 17'h0ABCD, 8'h00, 0);
        // Write straight after a read (turnaround), then read it back.
        op(0, 17'h00010, 8'h00, 0);
        op(1, 17'h00010, 8'hC3, 0);
        op(0, 17'h00010, 8'h00, 0);
        // Back-to-back writes, then reads.
        op(1, 17'h00020, 8'h11, 0);
        op(1, 17'h00021, 8'h22, 0);
        op(0, 17'h00021, 8'h00, 0);
        op(0, 17'h00020, 8'h00, 0);
        // R8: requests held while busy must be ignored; neighbours stay intact.
        op(0, 17'h00030, 8'h00, 1);
        op(1, 17'h00040, 8'h77, 1);
        op(0, 17'h00031, 8'h00, 0);
        op(0, 17'h00041, 8'h00, 0);
        // Random mix over a small window plus the full range.
        for (int i = 0; i < 300; i++) begin
            logic [16:0] a;
            a = ($urandom % 4 == 0) ? 17'($urandom) : 17'($urandom % 32);
            op(1'($urandom), a, 8'($urandom), 1'($urandom));
        end
        repeat (6) @(negedge clk);
        chk(exp_q.size() == 0 && rvalids == host_reads, "R9 one rvalid per read", rvalids, host_reads);
        chk(pin_writes == host_writes, "R8 no extra memory writes", pin_writes, host_writes);
        chk(contention == 0, "R5 driver overlap cycles", contention, 0);
        chk(idle_bad == 0, "R2 idle pin violations", idle_bad, 0);
        finish_up();
    end

endmodule